// File: doc/BRIEF.md
# GPIO Grouped Interrupt Controller

This block raises interrupts from a bank of general-purpose input pins. Rather than giving every pin its own interrupt, it provides eight shared interrupt slots. Each slot has a 4-bit route code that picks one source pin. The candidate pins for slot `g` are those whose index within their port, taken modulo eight, equals `g`. Each slot also has a 3-bit trigger code that selects level, edge or forced detection. Every slot keeps a sticky status bit. A mask register decides which slots may reach the single combined interrupt line.

Software reaches the block through a 32-bit register window with a single-cycle valid/ready handshake. To set a slot up, it writes the route code and the trigger code and then enables the mask bit. When the interrupt line rises, it reads the masked status word to find the pending slots. It clears each handled slot by writing a 1 to that slot's bit in the clear register. Pin inputs are asynchronous. A slot's routed pin passes through a two-flop synchronizer before detection.

Top module: `gpio_grp_irq`

## Requirements
- R1: After a synchronous reset the trigger, route and enable registers read 0, the masked status reads 0 and `irq_out` is low.
- R2: Registers sit at byte addresses 120 (trigger codes, field for slot g at bits 3g+2:3g, 24 bits), 124 (route codes, field for slot g at bits 4g+3:4g), 128 (enable bits 7:0) and 140 (masked status bits 7:0, read-only). Writable registers read back what was written, with bits above their width read as 0.
- R3: A request is accepted on a clock edge where `bus_valid` is high and `bus_ready` is low. `bus_ready` is then high for exactly the next cycle, and `bus_rdata` holds the read result. A write takes effect at the accepting edge.
- R4: Slot g's source is `pins_in[P*32 + S*8 + g]`, where P is route bits 3:2 (the port) and S is route bits 1:0. Pins outside that selection have no effect on the slot.
- R5: Trigger 1 (level high), 2 (level low) and 3 (always) set the slot's status on every cycle in which the condition holds. A pin change is visible in status on the third rising clock edge after it.
- R6: Trigger 5 latches status on a rising pin, 6 on a falling pin and 7 on either. Status stays set after the pin returns, until it is cleared.
- R7: Trigger codes 0 and 4 never set status.
- R8: Writing a word to byte address 132 clears the status of every slot whose bit is 1 in bits 7:0. Slots written with 0 keep their status. Address 132 reads as 0.
- R9: A set condition in the same cycle as a clear wins. A level condition that still holds, or an edge that arrives on the clearing edge, leaves status at 1.
- R10: Masked status equals status AND enable. `irq_out` is the OR of the masked status bits. A disabled slot keeps its status and shows it once enabled.
- R11: Reads of any address other than 120, 124, 128 and 140 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Request valid |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | One-cycle acknowledge of an accepted request |
| bus_rdata | output | 32 | Read data, valid while `bus_ready` is high |
| pins_in | input | 128 | Asynchronous pin inputs, four ports of 32 |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: four ports of 32 pins. With these values every one of the sixteen route codes points at a real pin, so the bench can reach all ports and all four sub-slots of each. It walks every trigger code, including the unused code 4, and pairs each one with a different slot and route code. It then aims an edge at the exact cycle of a clear and decoys pins that belong to the same slot number on unselected ports.

// File: rtl/gpio_grp_irq_pkg.sv
// Shared constants and types for the grouped GPIO interrupt controller.
// Assumes eight slots, 3-bit trigger codes and 4-bit route codes.
package gpio_grp_irq_pkg;

    localparam int TRIG_W = 3;
    localparam int SEL_W  = 4;
    localparam int SUB_W  = 2;

    localparam int ADR_TRIG  = 120;
    localparam int ADR_ROUTE = 124;
    localparam int ADR_EN    = 128;
    localparam int ADR_CLR   = 132;
    localparam int ADR_MSTAT = 140;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_OFF    = 3'd0,
        TRIG_HIGH   = 3'd1,
        TRIG_LOW    = 3'd2,
        TRIG_ALWAYS = 3'd3,
        TRIG_SPARE  = 3'd4,
        TRIG_RISE   = 3'd5,
        TRIG_FALL   = 3'd6,
        TRIG_BOTH   = 3'd7
    } trig_e;

endpackage

// File: rtl/gpio_grp_regs.sv
// Register window: trigger codes, route codes and enable mask, plus
// a clear-strobe decode and a masked status read.
// Assumes a requester that holds bus_valid until bus_ready is seen.
module gpio_grp_regs
    import gpio_grp_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NGRP   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_valid,
    input  logic                     bus_write,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [DATA_W-1:0]        bus_wdata,
    output logic                     bus_ready,
    output logic [DATA_W-1:0]        bus_rdata,
    output logic [NGRP*TRIG_W-1:0]   trig_o,
    output logic [NGRP*SEL_W-1:0]    route_o,
    output logic [NGRP-1:0]          en_o,
    output logic [NGRP-1:0]          clr_o,
    input  logic [NGRP-1:0]          mstat_i
);

    localparam int TRIG_BITS  = NGRP * TRIG_W;
    localparam int ROUTE_BITS = NGRP * SEL_W;

    logic                  ready_q;
    logic [DATA_W-1:0]     rdata_q;
    logic [TRIG_BITS-1:0]  trig_q;
    logic [ROUTE_BITS-1:0] route_q;
    logic [NGRP-1:0]       en_q;
    logic                  accept, wr_acc, rd_acc;
    logic                  hit_trig, hit_route, hit_en, hit_clr, hit_mstat;
    logic [DATA_W-1:0]     rmux;

    // Handshake and address decode.
    always_comb begin
        accept    = bus_valid && !ready_q;
        wr_acc    = accept && bus_write;
        rd_acc    = accept && !bus_write;
        hit_trig  = (bus_addr == ADDR_W'(ADR_TRIG));
        hit_route = (bus_addr == ADDR_W'(ADR_ROUTE));
        hit_en    = (bus_addr == ADDR_W'(ADR_EN));
        hit_clr   = (bus_addr == ADDR_W'(ADR_CLR));
        hit_mstat = (bus_addr == ADDR_W'(ADR_MSTAT));
    end

    // Acknowledge pulse one cycle after each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= accept;
    end

    // Trigger code register.
    always_ff @(posedge clk) begin
        if (!rst_n)                  trig_q <= '0;
        else if (wr_acc && hit_trig) trig_q <= bus_wdata[TRIG_BITS-1:0];
    end

    // Route code register.
    always_ff @(posedge clk) begin
        if (!rst_n)                   route_q <= '0;
        else if (wr_acc && hit_route) route_q <= bus_wdata[ROUTE_BITS-1:0];
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                en_q <= '0;
        else if (wr_acc && hit_en) en_q <= bus_wdata[NGRP-1:0];
    end

    // Clear strobe, valid only on the accepting edge.
    always_comb begin
        clr_o = (wr_acc && hit_clr) ? bus_wdata[NGRP-1:0] : '0;
    end

    // Read data select; unmapped and write-only addresses give zero.
    always_comb begin
        rmux = '0;
        if (hit_trig)       rmux[TRIG_BITS-1:0]  = trig_q;
        else if (hit_route) rmux[ROUTE_BITS-1:0] = route_q;
        else if (hit_en)    rmux[NGRP-1:0]       = en_q;
        else if (hit_mstat) rmux[NGRP-1:0]       = mstat_i;
    end

    // Read data capture at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata_q <= '0;
        else if (accept) rdata_q <= rd_acc ? rmux : '0;
    end

    assign bus_ready = ready_q;
    assign bus_rdata = rdata_q;
    assign trig_o    = trig_q;
    assign route_o   = route_q;
    assign en_o      = en_q;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (trig_q == '0 && route_q == '0 && en_q == '0));

    // R3
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    // R2
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_acc && hit_en) |=> $stable(en_q));

endmodule

// File: rtl/gpio_grp_route.sv
// Per-slot source multiplexer. Slot g may take pin (S*NGRP + g) of any
// port; the route code gives the port in its upper bits and S in its
// lower SUB_W bits. Codes naming a missing pin give a constant 0.
module gpio_grp_route
    import gpio_grp_irq_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int PORT_W = 32,
    parameter int NGRP   = 8
) (
    input  logic [NPORT*PORT_W-1:0] pins_i,
    input  logic [NGRP*SEL_W-1:0]   route_i,
    output logic [NGRP-1:0]         src_o
);

    localparam int NCAND = 1 << SEL_W;
    localparam int NSUB  = 1 << SUB_W;

    for (genvar g = 0; g < NGRP; g++) begin : g_slot
        logic [NCAND-1:0] cand;
        logic [SEL_W-1:0] code;

        for (genvar k = 0; k < NCAND; k++) begin : g_cand
            localparam int P = k / NSUB;
            localparam int S = k % NSUB;
            if (P < NPORT && (S * NGRP + g) < PORT_W) begin : g_real
                assign cand[k] = pins_i[P*PORT_W + S*NGRP + g];
            end else begin : g_none
                assign cand[k] = 1'b0;
            end
        end

        // Pick the candidate named by this slot's route code.
        always_comb begin
            code     = route_i[g*SEL_W +: SEL_W];
            src_o[g] = cand[code];
        end
    end

endmodule

// File: rtl/gpio_grp_sync.sv
// Two-flop synchronizer for the routed slot sources, plus one more
// stage holding the previous synchronized value for edge detection.
// Assumes sources are asynchronous to clk.
module gpio_grp_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] meta_q, cur_q, prev_q;

    // Synchronizing chain and history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/gpio_grp_slot.sv
// One interrupt slot: decodes the trigger code against the synchronized
// source and its previous value, and holds a sticky status bit.
// A set condition wins over a clear strobe in the same cycle.
module gpio_grp_slot
    import gpio_grp_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_i,
    input  logic              prev_i,
    input  logic [TRIG_W-1:0] trig_i,
    input  logic              clr_i,
    output logic              stat_o
);

    logic  stat_q, fire;
    trig_e mode;

    // Trigger condition for this cycle.
    always_comb begin
        mode = trig_e'(trig_i);
        case (mode)
            TRIG_HIGH:   fire = cur_i;
            TRIG_LOW:    fire = !cur_i;
            TRIG_ALWAYS: fire = 1'b1;
            TRIG_RISE:   fire = cur_i && !prev_i;
            TRIG_FALL:   fire = !cur_i && prev_i;
            TRIG_BOTH:   fire = cur_i ^ prev_i;
            default:     fire = 1'b0;
        endcase
    end

    // Sticky status: set wins, otherwise clear, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     stat_q <= 1'b0;
        else if (fire)  stat_q <= 1'b1;
        else if (clr_i) stat_q <= 1'b0;
    end

    assign stat_o = stat_q;

    // R6
    rise_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_i == TRIG_RISE && cur_i && !prev_i) |=> stat_q);

    // R7
    inert_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig_i == TRIG_OFF || trig_i == TRIG_SPARE) && !stat_q) |=> !stat_q);

    // R9
    level_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && trig_i == TRIG_HIGH && cur_i) |=> stat_q);

    // R8
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (trig_i == TRIG_OFF || trig_i == TRIG_SPARE)) |=> !stat_q);

endmodule

// File: rtl/gpio_grp_irq.sv
// Top of the grouped GPIO interrupt controller: register window,
// per-slot routing, synchronizer and slot detectors, combined output.
// Assumes NGRP*SEL_W and NGRP*TRIG_W fit in DATA_W.
module gpio_grp_irq
    import gpio_grp_irq_pkg::*;
#(
    parameter int NPORT  = 4,
    parameter int PORT_W = 32,
    parameter int NGRP   = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_valid,
    input  logic                    bus_write,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DATA_W-1:0]       bus_wdata,
    output logic                    bus_ready,
    output logic [DATA_W-1:0]       bus_rdata,
    input  logic [NPORT*PORT_W-1:0] pins_in,
    output logic                    irq_out
);

    logic [NGRP*TRIG_W-1:0] trig;
    logic [NGRP*SEL_W-1:0]  route;
    logic [NGRP-1:0]        en, clr, src, cur, prev, stat, mstat;

    gpio_grp_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NGRP(NGRP)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .trig_o(trig), .route_o(route), .en_o(en), .clr_o(clr),
        .mstat_i(mstat)
    );

    gpio_grp_route #(
        .NPORT(NPORT), .PORT_W(PORT_W), .NGRP(NGRP)
    ) u_route (
        .pins_i(pins_in), .route_i(route), .src_o(src)
    );

    gpio_grp_sync #(
        .WIDTH(NGRP)
    ) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(src), .cur_o(cur), .prev_o(prev)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_slot
        gpio_grp_slot u_slot (
            .clk(clk), .rst_n(rst_n),
            .cur_i(cur[g]), .prev_i(prev[g]),
            .trig_i(trig[g*TRIG_W +: TRIG_W]),
            .clr_i(clr[g]),
            .stat_o(stat[g])
        );
    end

    // Masked status and the combined request.
    always_comb begin
        mstat   = stat & en;
        irq_out = |mstat;
    end

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (en != '0));

endmodule

// File: tb/gpio_grp_irq_test.sv
`timescale 1ns/1ps
module gpio_grp_irq_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_valid = 1'b0;
    logic         bus_write = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic         bus_ready;
    logic [31:0]  bus_rdata;
    logic [127:0] pins_in = '0;
    logic         irq_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_grp_irq uut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata),
        .pins_in(pins_in), .irq_out(irq_out)
    );

    localparam logic [7:0] A_TRIG = 8'd120, A_ROUTE = 8'd124, A_EN = 8'd128,
                           A_CLR = 8'd132, A_MSTAT = 8'd140;

    // Vector: slot, trigger, route, expected bits idle/high/high+clr/low/low+clr
    localparam logic [14:0] VEC [0:8] = '{
        {3'd0, 3'd0, 4'd0,  5'b00000},
        {3'd1, 3'd1, 4'd5,  5'b01110},
        {3'd2, 3'd2, 4'd10, 5'b11011},
        {3'd3, 3'd3, 4'd15, 5'b11111},
        {3'd4, 3'd4, 4'd3,  5'b00000},
        {3'd5, 3'd5, 4'd6,  5'b01000},
        {3'd6, 3'd6, 4'd9,  5'b00010},
        {3'd7, 3'd7, 4'd12, 5'b01010},
        {3'd0, 3'd5, 4'd13, 5'b01000}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] r);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        r = bus_rdata;
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] dummy;
        xfer(1'b1, a, d, dummy);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] r);
        xfer(1'b0, a, 32'h0, r);
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic tidy();
        wr(A_TRIG, 32'h0);
        @(negedge clk); pins_in = '0;
        cycles(4);
        wr(A_CLR, 32'hFF);
        wr(A_EN, 32'hFF);
    endtask

    function automatic int pin_of(input int route, input int slot);
        return (route >> 2) * 32 + (route & 3) * 8 + slot;
    endfunction

    initial begin
        logic [31:0] r;
        cycles(3);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd(A_TRIG, r);  check("R1 trigger reset", r, 32'h0);
        rd(A_ROUTE, r); check("R1 route reset", r, 32'h0);
        rd(A_EN, r);    check("R1 enable reset", r, 32'h0);
        rd(A_MSTAT, r); check("R1 status reset", r, 32'h0);
        check("R1 irq reset", {31'h0, irq_out}, 32'h0);

        // R2 readback and widths
        wr(A_TRIG, 32'hFFFFFFFF);  rd(A_TRIG, r);  check("R2 trigger width", r, 32'h00FFFFFF);
        wr(A_TRIG, 32'h0);         rd(A_TRIG, r);  check("R2 trigger clear", r, 32'h0);
        wr(A_ROUTE, 32'hA5C31E07); rd(A_ROUTE, r); check("R2 route readback", r, 32'hA5C31E07);
        wr(A_EN, 32'h1FF);         rd(A_EN, r);    check("R2 enable width", r, 32'hFF);

        // R11 unmapped and write-only addresses
        rd(A_CLR, r);  check("R8 R11 clear address reads 0", r, 32'h0);
        rd(8'd136, r); check("R11 addr 136", r, 32'h0);
        rd(8'd0, r);   check("R11 addr 0", r, 32'h0);
        rd(8'd121, r); check("R11 misaligned 121", r, 32'h0);

        // R3 handshake timing
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = A_ROUTE;
        check("R3 ready low before accept", {31'h0, bus_ready}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R3 ready after accept", {31'h0, bus_ready}, 32'h1);
        check("R3 read data", bus_rdata, 32'hA5C31E07);
        bus_valid = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R3 ready one cycle", {31'h0, bus_ready}, 32'h0);
        wr(A_ROUTE, 32'h0);
        tidy();

        // R4 R5 R6 R7 R9: table walk over trigger codes
        for (int v = 0; v < 9; v++) begin
            int slot, code, route, p;
            logic [4:0] e;
            slot  = int'(VEC[v][14:12]);
            code  = int'(VEC[v][11:9]);
            route = int'(VEC[v][8:5]);
            e     = VEC[v][4:0];
            p     = pin_of(route, slot);
            wr(A_ROUTE, 32'(route) << (4 * slot));
            wr(A_TRIG, 32'(code) << (3 * slot));
            cycles(4);
            wr(A_CLR, 32'hFF);
            rd(A_MSTAT, r);
            check($sformatf("R5 R7 vec%0d idle", v), r, 32'(e[4]) << slot);
            @(negedge clk); pins_in[p] = 1'b1;
            cycles(4);
            rd(A_MSTAT, r);
            check($sformatf("R4 R6 vec%0d high", v), r, 32'(e[3]) << slot);
            check($sformatf("R10 vec%0d irq", v), {31'h0, irq_out}, {31'h0, e[3]});
            wr(A_CLR, 32'hFF);
            rd(A_MSTAT, r);
            check($sformatf("R9 vec%0d high after clear", v), r, 32'(e[2]) << slot);
            @(negedge clk); pins_in[p] = 1'b0;
            cycles(4);
            rd(A_MSTAT, r);
            check($sformatf("R6 vec%0d low", v), r, 32'(e[1]) << slot);
            wr(A_CLR, 32'hFF);
            rd(A_MSTAT, r);
            check($sformatf("R8 vec%0d low after clear", v), r, 32'(e[0]) << slot);
            wr(A_ROUTE, 32'h0);
            tidy();
        end

        // R5 latency: a change shows on the third edge
        wr(A_TRIG, 32'(5));
        @(negedge clk); pins_in[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R5 no irq after two edges", {31'h0, irq_out}, 32'h0);
        @(posedge clk); @(negedge clk);
        check("R5 irq after third edge", {31'h0, irq_out}, 32'h1);
        tidy();

        // R4 decoys on unselected ports for the same slot number
        wr(A_ROUTE, 32'h6 << 12);
        wr(A_TRIG, 32'h7 << 9);
        cycles(4);
        wr(A_CLR, 32'hFF);
        @(negedge clk); pins_in[3] = 1'b1; pins_in[67] = 1'b1; pins_in[52] = 1'b1;
        cycles(4);
        rd(A_MSTAT, r); check("R4 decoy pins ignored", r, 32'h0);
        @(negedge clk); pins_in[51] = 1'b1;
        cycles(4);
        rd(A_MSTAT, r); check("R4 routed pin 51", r, 32'h8);
        wr(A_ROUTE, 32'h0);
        tidy();

        // R10 disabled slot keeps status
        wr(A_EN, 32'h0);
        wr(A_TRIG, 32'h5 << 3);
        @(negedge clk); pins_in[1] = 1'b1;
        cycles(4);
        @(negedge clk);
        check("R10 disabled irq low", {31'h0, irq_out}, 32'h0);
        rd(A_MSTAT, r); check("R10 disabled masked read", r, 32'h0);
        wr(A_EN, 32'h02);
        @(negedge clk);
        check("R10 enabled irq high", {31'h0, irq_out}, 32'h1);
        rd(A_MSTAT, r); check("R10 enabled masked read", r, 32'h02);
        tidy();

        // R8 selective clear
        wr(A_TRIG, (32'h5 << 3) | (32'h5 << 6));
        @(negedge clk); pins_in[1] = 1'b1; pins_in[2] = 1'b1;
        cycles(4);
        rd(A_MSTAT, r); check("R8 two pending", r, 32'h06);
        wr(A_CLR, 32'h02);
        rd(A_MSTAT, r); check("R8 clear one slot", r, 32'h04);
        wr(A_CLR, 32'h0);
        rd(A_MSTAT, r); check("R8 zero write no effect", r, 32'h04);
        tidy();

        // R9 edge arriving on the clearing edge wins
        wr(A_TRIG, 32'h5);
        cycles(4);
        wr(A_CLR, 32'hFF);
        @(negedge clk); pins_in[0] = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(A_CLR, 32'h01);
        rd(A_MSTAT, r); check("R9 edge beats clear", r, 32'h01);
        tidy();

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cycles(50000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule